// File: doc/BRIEF.md
# DMA Channel Request and Mask Register Block

This block keeps the software request flags and the per-channel mask flags for one four-channel DMA controller. Software writes single bytes to two ports: a request port and a single-channel mask port. Both ports use the same byte layout. The low two bits pick a channel and bit 2 gives the new value for that channel's flag.

Each cycle the block combines three things into one request line per channel for a downstream priority encoder:
- the hardware request pins, gated by their masks;
- the software requests, gated by each channel's block-mode setting;
- a cascade mask input from the second controller.

The per-channel mode bits and the terminal-count pulses come in from outside the block. A terminal count clears the software request. It also sets the mask, except on channels that autoinitialize. The software request flags are also driven out as the upper status nibble.

Top module: `dma_reqmask`

## Requirements
- R1: After reset, and in the cycle after a master-clear pulse, all software request flags are 0, all mask flags are 1, and the effective request output is 0.
- R2: A write with `cs`, `wr` high and `port_sel`=0 selects a channel with `wdata[1:0]` and loads `wdata[2]` into that channel's software request flag. A 1 sets the flag and a 0 clears it. `wdata[7:3]` have no effect.
- R3: A write with `cs`, `wr` high and `port_sel`=1 selects a channel with `wdata[1:0]` and loads `wdata[2]` into that channel's mask flag. A 1 masks the channel and a 0 unmasks it.
- R4: A hardware request on `dreq[i]` reaches `eff_req[i]` only while mask flag i is 0. `eff_req` is registered, so it reflects the register state one clock after that state is updated.
- R5: A set software request drives `eff_req[i]` regardless of the mask, but only while `block_mode[i]` is 1.
- R6: A `tc[i]` pulse clears software request flag i. This takes precedence over a same-cycle request-port write to that channel.
- R7: A `tc[i]` pulse sets mask flag i when `autoinit[i]` is 0. When `autoinit[i]` is 1, the mask flag is left unchanged.
- R8: While `casc_mask` is 1, every bit of `eff_req` is 0 on the next clock, whatever the hardware and software requests are.
- R9: `sreq_stat[i]` equals software request flag i. These four bits form status bits [7:4].
- R10: A port write has no effect unless `cs` and `wr` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Synchronous master clear |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write strobe |
| port_sel | input | 1 | 0 selects the request port, 1 selects the single-mask port |
| wdata | input | 8 | Write byte |
| dreq | input | 4 | Hardware request pins |
| block_mode | input | 4 | Per-channel block-mode setting |
| autoinit | input | 4 | Per-channel autoinitialize setting |
| tc | input | 4 | Per-channel terminal-count pulse |
| casc_mask | input | 1 | Mask flag of the second controller's cascade channel |
| eff_req | output | 4 | Effective requests to the priority encoder |
| mask | output | 4 | Current mask flags |
| sreq_stat | output | 4 | Software request flags, status bits [7:4] |

## Verification
Two functions can act on one flag in the same cycle: a software port write and a terminal-count pulse. The bench provokes this by driving a request-port write that sets channel 0 in the same clock as `tc[0]`. It then checks that the flag reads back cleared. The mask flag is covered the same way, with a write on an autoinitializing channel arriving alongside its terminal count. There the write is expected to win, because the terminal count has no effect on the mask of that channel.

// File: rtl/dma_reqmask.sv
module dma_reqmask #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mclr,
  input  logic           cs,
  input  logic           wr,
  input  logic           port_sel,
  input  logic [7:0]     wdata,
  input  logic [NCH-1:0] dreq,
  input  logic [NCH-1:0] block_mode,
  input  logic [NCH-1:0] autoinit,
  input  logic [NCH-1:0] tc,
  input  logic           casc_mask,
  output logic [NCH-1:0] eff_req,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] sreq_stat
);

  logic [NCH-1:0] sreq;
  logic [CW-1:0]  chan;
  logic           val, req_wr, msk_wr;

  assign chan   = wdata[CW-1:0];
  assign val    = wdata[CW];
  assign req_wr = cs & wr & ~port_sel;
  assign msk_wr = cs & wr & port_sel;
  assign sreq_stat = sreq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreq    <= '0;
      mask    <= '1;
      eff_req <= '0;
    end else if (mclr) begin
      sreq    <= '0;
      mask    <= '1;
      eff_req <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (tc[i])                          sreq[i] <= 1'b0;
        else if (req_wr && chan == CW'(i))  sreq[i] <= val;
        if (tc[i] && !autoinit[i])          mask[i] <= 1'b1;
        else if (msk_wr && chan == CW'(i))  mask[i] <= val;
      end
      eff_req <= casc_mask ? '0 : ((dreq & ~mask) | (sreq & block_mode));
    end
  end

  // R1
  mclr_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (sreq == '0 && mask == '1 && eff_req == '0));

  // R6
  tc_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc) |=> ((sreq & $past(tc)) == '0));

  // R7
  tc_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tc & ~autoinit)) |=> ((~mask & $past(tc & ~autoinit)) == '0));

  // R8
  cascade_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    casc_mask |=> (eff_req == '0));

  // R10
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs && wr) && tc == '0 && !mclr) |=> ($stable(sreq) && $stable(mask)));

endmodule

// File: tb/dma_reqmask_test.sv
module dma_reqmask_test;
  logic clk = 0, rst_n = 0, mclr = 0, cs = 0, wr = 0, port_sel = 0, casc_mask = 0;
  logic [7:0] wdata = 0;
  logic [3:0] dreq = 0, block_mode = 0, autoinit = 0, tc = 0;
  logic [3:0] eff_req, mask, sreq_stat;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  dma_reqmask uut (.clk, .rst_n, .mclr, .cs, .wr, .port_sel, .wdata, .dreq,
    .block_mode, .autoinit, .tc, .casc_mask, .eff_req, .mask, .sreq_stat);

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(logic s, logic [7:0] d, logic [3:0] t, logic c = 1, logic w = 1);
    @(negedge clk);
    cs = c; wr = w; port_sel = s; wdata = d; tc = t;
    @(negedge clk);
    cs = 0; wr = 0; tc = 0;
  endtask

  task automatic settle(); @(negedge clk); endtask

  task automatic t_reset();
    check("R1 sreq", sreq_stat, 4'b0000);
    check("R1 mask", mask, 4'b1111);
    check("R1 eff", eff_req, 4'b0000);
  endtask

  task automatic t_hw();
    dreq = 4'hF; settle(); settle();
    check("R4 all masked", eff_req, 4'b0000);
    cyc(1, 8'h01, 0);
    check("R3 unmask ch1", mask, 4'b1101);
    settle();
    check("R4 ch1 passes", eff_req, 4'b0010);
    dreq = 0;
  endtask

  task automatic t_sw();
    cyc(0, 8'h06, 0);
    check("R2 set ch2", sreq_stat, 4'b0100);
    check("R9 status", sreq_stat, 4'b0100);
    settle();
    check("R5 no block mode", eff_req, 4'b0000);
    block_mode = 4'b0100; settle(); settle();
    check("R5 bypasses mask", eff_req, 4'b0100);
    cyc(0, 8'hFF, 0);
    check("R2 reserved ignored", sreq_stat, 4'b1100);
    cyc(0, 8'h02, 0);
    check("R2 clear ch2", sreq_stat, 4'b1000);
    cyc(0, 8'h05, 0, 0, 1);
    check("R10 no cs", sreq_stat, 4'b1000);
    cyc(1, 8'h01, 0, 1, 0);
    check("R10 no wr", mask, 4'b1101);
    block_mode = 0;
  endtask

  task automatic t_tc();
    cyc(1, 8'h00, 0);
    cyc(0, 8'h04, 0);
    check("R2 set ch0", sreq_stat, 4'b1001);
    cyc(0, 8'h00, 4'b0001, 0, 0);
    check("R6 tc clears req", sreq_stat, 4'b1000);
    check("R7 tc sets mask", mask, 4'b1101);
    autoinit = 4'b0010;
    cyc(0, 8'h00, 4'b0010, 0, 0);
    check("R7 autoinit keeps mask", mask, 4'b1101);
    cyc(0, 8'h04, 4'b0001);
    check("R6 tc beats write", sreq_stat, 4'b1000);
    cyc(1, 8'h05, 4'b0010);
    check("R7 autoinit write wins", mask, 4'b1111);
    autoinit = 0;
  endtask

  task automatic t_casc();
    for (int i = 0; i < 4; i++) cyc(1, 8'(i), 0);
    dreq = 4'hF; casc_mask = 1; settle(); settle();
    check("R8 cascade blocks", eff_req, 4'b0000);
    casc_mask = 0; settle(); settle();
    check("R4 unmasked all", eff_req, 4'b1111);
    dreq = 0;
  endtask

  task automatic t_mclr();
    cyc(0, 8'h05, 0);
    @(negedge clk); mclr = 1; @(negedge clk); mclr = 0;
    check("R1 mclr sreq", sreq_stat, 4'b0000);
    check("R1 mclr mask", mask, 4'b1111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    t_reset(); t_hw(); t_sw(); t_tc(); t_casc(); t_mclr();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule